// File: doc/BRIEF.md
# Masked Time and Date Alarm

This block watches the running time and date of a real-time clock and raises an alarm when they agree with a programmed alarm setting. Two alarm words hold the setting. One covers second, minute, hour and the AM/PM bit; the other covers day of month and month. Each of the five fields has its own enable bit, and only enabled fields take part in the comparison. All values are BCD. Software writes the alarm words through a simple one-cycle write port and can read them back on dedicated outputs.

The clock counter is outside this block. It presents its current fields and a one-cycle `sec_tick` pulse each time the time advances. The comparison is made only in tick cycles. A successful comparison sets a sticky alarm flag, and a write-one clear input resets that flag. The block also decodes both alarm words for out-of-range BCD contents. While either word is marked non-valid, the alarm cannot fire.

Top module: `rtc_alarm_matcher`

## Requirements
- R1: Writing with `reg_sel`=0 loads the time alarm word and `reg_sel`=1 loads the date alarm word, in the cycle after `reg_wr`. Time word layout: second 6:0, second enable 7, minute 14:8, minute enable 15, hour 21:16, AM/PM 22, hour enable 23. Date word layout: month 20:16, month enable 23, day of month 29:24, day enable 31. All other bits store nothing and read back 0, and a write to one word leaves the other unchanged.
- R2: After a synchronous active-low reset, both alarm words read 0 with every field disabled, the alarm flag is 0 and both non-valid outputs are 0.
- R3: In a cycle where `sec_tick` is 1 and every enabled field equals the corresponding current value, `alarm_flag` is 1 from the next cycle.
- R4: Once set, `alarm_flag` stays 1 until it is cleared.
- R5: A cycle with `alarm_clr`=1 makes `alarm_flag` 0 in the next cycle. If a match fires in that same cycle, the flag is 1 instead, because setting takes priority.
- R6: With no field enabled, the alarm never fires.
- R7: Matches are evaluated only in cycles with `sec_tick`=1. A match held across cycles without a tick does not set the flag, and neither does a match held after a clear within the same second.
- R8: The alarm AM/PM bit is compared with `cur_pm` only when the hour enable is set and `mode_12h`=1. In 24-hour mode only the hour digits are compared.
- R9: `time_alarm_bad` is 1 in any of these cases: an enabled second or minute is not BCD 00..59; an enabled hour is not BCD 01..12 in 12-hour mode; an enabled hour is not BCD 00..23 in 24-hour mode. `date_alarm_bad` is 1 when an enabled day is not BCD 01..31 or an enabled month is not BCD 01..12. A BCD value with a low digit above 9 is out of range. Disabled fields are not checked. Both outputs follow the stored words and `mode_12h` without delay.
- R10: While either non-valid output is 1, no tick sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse when the current time advances |
| cur_sec | input | 7 | Current second, BCD |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD |
| cur_pm | input | 1 | Current AM/PM, 1 = PM |
| cur_date | input | 6 | Current day of month, BCD |
| cur_month | input | 5 | Current month, BCD |
| mode_12h | input | 1 | 1 = 12-hour clock, 0 = 24-hour clock |
| reg_wr | input | 1 | Alarm word write strobe |
| reg_sel | input | 1 | 0 = time alarm word, 1 = date alarm word |
| reg_wdata | input | 32 | Write data |
| alarm_clr | input | 1 | Write-one clear of the alarm flag |
| time_alarm_rd | output | 32 | Stored time alarm word |
| date_alarm_rd | output | 32 | Stored date alarm word |
| alarm_flag | output | 1 | Sticky alarm flag |
| time_alarm_bad | output | 1 | Time alarm word holds an out-of-range enabled field |
| date_alarm_bad | output | 1 | Date alarm word holds an out-of-range enabled field |

## Verification
The bench targets four kinds of fault.

- **Reset state.** All fields zero and disabled must not match. A design that treated an all-disabled word as a full match would raise the flag on the first tick.
- **AM/PM handling.** The bench runs the same hour with the wrong AM/PM in both clock modes. An AM/PM compare that ignored the mode would block the 24-hour match, and one that dropped the bit would fire at the wrong half of the day in 12-hour mode.
- **Flag timing.** The bench holds a match without ticks after a clear, which catches a level-sensitive flag. It also raises clear and a firing tick together, which catches the wrong priority.
- **Validity decode.** Out-of-range hours are probed under both modes, along with bad low digits and illegal values in disabled fields. A wrong range decode shows up as a wrong non-valid output or as an alarm that fires on an illegal setting.

// File: rtl/rtc_alarm_pkg.sv
// Shared field layout and BCD range helper for the masked alarm.
// Assumes all calendar and time values are packed BCD.
package rtc_alarm_pkg;

    localparam int WORD_W     = 32;
    localparam int SEC_W      = 7;
    localparam int MIN_W      = 7;
    localparam int HOUR_W     = 6;
    localparam int DAY_W      = 6;
    localparam int MON_W      = 5;
    localparam int NUM_FIELDS = 5;
    localparam int CMP_W      = 8;
    localparam int NUM_WORDS  = 2;

    localparam logic [WORD_W-1:0] TIME_KEEP = 32'h00FF_FFFF;
    localparam logic [WORD_W-1:0] DATE_KEEP = 32'hBF9F_0000;

    // time alarm word, bits 23:0
    typedef struct packed {
        logic              hour_en;
        logic              pm;
        logic [HOUR_W-1:0] hour;
        logic              min_en;
        logic [MIN_W-1:0]  min;
        logic              sec_en;
        logic [SEC_W-1:0]  sec;
    } time_alarm_t;

    // date alarm word, only the decoded fields
    typedef struct packed {
        logic             day_en;
        logic [DAY_W-1:0] day;
        logic             mon_en;
        logic [MON_W-1:0] mon;
    } date_alarm_t;

    // true when the BCD value v lies in lo..hi and its low digit is legal
    function automatic logic bcd_in_range(input logic [CMP_W-1:0] v,
                                          input int lo, input int hi);
        int val;
        if (v[3:0] > 4'd9) return 1'b0;
        val = int'(v[7:4]) * 10 + int'(v[3:0]);
        return (val >= lo) && (val <= hi);
    endfunction

endpackage

// File: rtl/rtc_alarm_words.sv
// Storage for the two alarm words.
// Each word keeps only its defined bits; the rest always read 0.
// Assumes a write lasts one cycle and reg_sel is valid with it.
module rtc_alarm_words
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              sel_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] time_q_o,
    output logic [WORD_W-1:0] date_q_o
);

    localparam logic [NUM_WORDS-1:0][WORD_W-1:0] KEEP = {DATE_KEEP, TIME_KEEP};

    logic [NUM_WORDS-1:0][WORD_W-1:0] word_q;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        // load the selected word with its undefined bits forced to 0
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[w] <= '0;
            end else if (wr_i && (sel_i == 1'(w))) begin
                word_q[w] <= wdata_i & KEEP[w];
            end
        end

        // R1: an unselected word keeps its value
        a_r1_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_i && (sel_i == 1'(w))) |=> $stable(word_q[w]));
    end

    assign time_q_o = word_q[0];
    assign date_q_o = word_q[1];

endmodule

// File: rtl/rtc_alarm_check.sv
// Range decode of the enabled alarm fields.
// A disabled field is never reported. The hour range follows the clock mode.
module rtc_alarm_check
    import rtc_alarm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  time_alarm_t tword_i,
    input  date_alarm_t dword_i,
    input  logic        mode_12h_i,
    output logic        time_bad_o,
    output logic        date_bad_o
);

    int hour_lo;
    int hour_hi;

    // pick the legal hour window for the current clock mode
    always_comb begin
        hour_lo = mode_12h_i ? 1 : 0;
        hour_hi = mode_12h_i ? 12 : 23;
    end

    // flag any enabled time field outside its BCD window
    always_comb begin
        time_bad_o = 1'b0;
        if (tword_i.sec_en && !bcd_in_range({1'b0, tword_i.sec}, 0, 59))
            time_bad_o = 1'b1;
        if (tword_i.min_en && !bcd_in_range({1'b0, tword_i.min}, 0, 59))
            time_bad_o = 1'b1;
        if (tword_i.hour_en && !bcd_in_range({2'b0, tword_i.hour}, hour_lo, hour_hi))
            time_bad_o = 1'b1;
    end

    // flag any enabled date field outside its BCD window
    always_comb begin
        date_bad_o = 1'b0;
        if (dword_i.day_en && !bcd_in_range({2'b0, dword_i.day}, 1, 31))
            date_bad_o = 1'b1;
        if (dword_i.mon_en && !bcd_in_range({3'b0, dword_i.mon}, 1, 12))
            date_bad_o = 1'b1;
    end

    // R9: a word with every field disabled is never reported
    a_r9_time_idle_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (!tword_i.sec_en && !tword_i.min_en && !tword_i.hour_en) |-> !time_bad_o);
    a_r9_date_idle_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (!dword_i.day_en && !dword_i.mon_en) |-> !date_bad_o);

endmodule

// File: rtl/rtc_alarm_compare.sv
// Per-field masked comparison of the alarm against the current time.
// Produces a one-cycle fire pulse in tick cycles only.
// Assumes the current fields are stable in the tick cycle.
module rtc_alarm_compare
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  time_alarm_t       tword_i,
    input  date_alarm_t       dword_i,
    input  logic              mode_12h_i,
    input  logic              tick_i,
    input  logic [SEC_W-1:0]  sec_i,
    input  logic [MIN_W-1:0]  min_i,
    input  logic [HOUR_W-1:0] hour_i,
    input  logic              pm_i,
    input  logic [DAY_W-1:0]  day_i,
    input  logic [MON_W-1:0]  mon_i,
    input  logic              time_bad_i,
    input  logic              date_bad_i,
    output logic              fire_o
);

    logic [NUM_FIELDS-1:0] en;
    logic [CMP_W-1:0]      alm_v [NUM_FIELDS];
    logic [CMP_W-1:0]      cur_v [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] hit;
    logic                  pm_used;

    // the AM/PM bit joins the hour only in 12-hour mode
    assign pm_used = mode_12h_i;

    // gather enables and operands, one slot per field
    always_comb begin
        en = {dword_i.mon_en, dword_i.day_en, tword_i.hour_en,
              tword_i.min_en, tword_i.sec_en};
        alm_v[0] = {1'b0, tword_i.sec};
        cur_v[0] = {1'b0, sec_i};
        alm_v[1] = {1'b0, tword_i.min};
        cur_v[1] = {1'b0, min_i};
        alm_v[2] = {1'b0, pm_used & tword_i.pm, tword_i.hour};
        cur_v[2] = {1'b0, pm_used & pm_i, hour_i};
        alm_v[3] = {2'b0, dword_i.day};
        cur_v[3] = {2'b0, day_i};
        alm_v[4] = {3'b0, dword_i.mon};
        cur_v[4] = {3'b0, mon_i};
    end

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        // a disabled field always agrees
        assign hit[f] = !en[f] || (alm_v[f] == cur_v[f]);
    end

    // full match: tick, at least one field armed, all agree, both words legal
    assign fire_o = tick_i && (|en) && (&hit) && !time_bad_i && !date_bad_i;

    // R6: nothing armed means nothing fires
    a_r6_none_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (!tword_i.sec_en && !tword_i.min_en && !tword_i.hour_en &&
         !dword_i.day_en && !dword_i.mon_en) |-> !fire_o);
    // R7: fire only in tick cycles
    a_r7_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |-> !fire_o);
    // R10: an illegal word blocks firing
    a_r10_bad_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (time_bad_i || date_bad_i) |-> !fire_o);

endmodule

// File: rtl/rtc_alarm_flag.sv
// Sticky alarm flag with write-one clear.
// SET_WINS selects which of set and clear prevails when both arrive together.
module rtc_alarm_flag #(
    parameter bit SET_WINS = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_d;

    if (SET_WINS) begin : g_set_first
        // a new event beats a simultaneous clear
        assign flag_d = set_i ? 1'b1 : (clr_i ? 1'b0 : flag_o);
    end else begin : g_clr_first
        // a clear beats a simultaneous event
        assign flag_d = clr_i ? 1'b0 : (set_i ? 1'b1 : flag_o);
    end

    // hold the flag state
    always_ff @(posedge clk) begin
        if (!rst_n) flag_o <= 1'b0;
        else        flag_o <= flag_d;
    end

    // R3: a lone event sets the flag
    a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> flag_o);
    // R4: the flag holds without a clear
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
    // R5: a lone clear drops the flag
    a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);

endmodule

// File: rtl/rtc_alarm_matcher.sv
// Top of the masked time and date alarm.
// Holds the alarm words, decodes their legality, compares them with the
// current clock fields on each second tick and keeps a sticky alarm flag.
// Assumes the clock counter supplies BCD fields and a one-cycle tick.
module rtc_alarm_matcher
    import rtc_alarm_pkg::*;
#(
    parameter bit SET_WINS = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic [SEC_W-1:0]  cur_sec,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic              cur_pm,
    input  logic [DAY_W-1:0]  cur_date,
    input  logic [MON_W-1:0]  cur_month,
    input  logic              mode_12h,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              alarm_clr,
    output logic [WORD_W-1:0] time_alarm_rd,
    output logic [WORD_W-1:0] date_alarm_rd,
    output logic              alarm_flag,
    output logic              time_alarm_bad,
    output logic              date_alarm_bad
);

    time_alarm_t tword;
    date_alarm_t dword;
    logic        fire;

    rtc_alarm_words i_words (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (reg_wr),
        .sel_i    (reg_sel),
        .wdata_i  (reg_wdata),
        .time_q_o (time_alarm_rd),
        .date_q_o (date_alarm_rd)
    );

    // unpack the stored words into their fields
    always_comb begin
        tword = time_alarm_t'(time_alarm_rd[23:0]);
        dword = '{day_en: date_alarm_rd[31], day: date_alarm_rd[29:24],
                  mon_en: date_alarm_rd[23], mon: date_alarm_rd[20:16]};
    end

    rtc_alarm_check i_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .tword_i    (tword),
        .dword_i    (dword),
        .mode_12h_i (mode_12h),
        .time_bad_o (time_alarm_bad),
        .date_bad_o (date_alarm_bad)
    );

    rtc_alarm_compare i_compare (
        .clk        (clk),
        .rst_n      (rst_n),
        .tword_i    (tword),
        .dword_i    (dword),
        .mode_12h_i (mode_12h),
        .tick_i     (sec_tick),
        .sec_i      (cur_sec),
        .min_i      (cur_min),
        .hour_i     (cur_hour),
        .pm_i       (cur_pm),
        .day_i      (cur_date),
        .mon_i      (cur_month),
        .time_bad_i (time_alarm_bad),
        .date_bad_i (date_alarm_bad),
        .fire_o     (fire)
    );

    rtc_alarm_flag #(.SET_WINS(SET_WINS)) i_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (fire),
        .clr_i  (alarm_clr),
        .flag_o (alarm_flag)
    );

    // R2: reset leaves the flag low
    a_r2_reset_flag: assert property (@(posedge clk)
        !rst_n |=> !alarm_flag);

endmodule

// File: tb/test_rtc_alarm_matcher.sv
module test_rtc_alarm_matcher;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic [6:0]  cur_sec = '0;
    logic [6:0]  cur_min = '0;
    logic [5:0]  cur_hour = '0;
    logic        cur_pm = 1'b0;
    logic [5:0]  cur_date = '0;
    logic [4:0]  cur_month = '0;
    logic        mode_12h = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        alarm_clr = 1'b0;
    logic [31:0] time_alarm_rd;
    logic [31:0] date_alarm_rd;
    logic        alarm_flag;
    logic        time_alarm_bad;
    logic        date_alarm_bad;

    int n_tests = 0;
    int n_fail  = 0;
    bit cmp_on  = 1'b0;
    bit done    = 1'b0;

    // behavioural model state
    int unsigned m_time = 0;
    int unsigned m_date = 0;
    bit          m_flag = 1'b0;

    always #5 clk = ~clk;

    rtc_alarm_matcher i_rtc_alarm_matcher (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_pm(cur_pm), .cur_date(cur_date), .cur_month(cur_month),
        .mode_12h(mode_12h), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .alarm_clr(alarm_clr),
        .time_alarm_rd(time_alarm_rd), .date_alarm_rd(date_alarm_rd),
        .alarm_flag(alarm_flag), .time_alarm_bad(time_alarm_bad),
        .date_alarm_bad(date_alarm_bad)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic bit bcd_ok(input int v, input int lo, input int hi);
        int val;
        if ((v % 16) > 9) return 1'b0;
        val = (v / 16) * 10 + (v % 16);
        return val >= lo && val <= hi;
    endfunction

    function automatic bit m_time_bad();
        int s  = int'(m_time % 128);
        int mi = int'((m_time / 256) % 128);
        int h  = int'((m_time / 65536) % 64);
        bit b  = 1'b0;
        if (m_time[7]  && !bcd_ok(s, 0, 59)) b = 1'b1;
        if (m_time[15] && !bcd_ok(mi, 0, 59)) b = 1'b1;
        if (m_time[23] && !bcd_ok(h, mode_12h ? 1 : 0, mode_12h ? 12 : 23)) b = 1'b1;
        return b;
    endfunction

    function automatic bit m_date_bad();
        int mo = int'((m_date / 65536) % 32);
        int d  = int'((m_date / 16777216) % 64);
        bit b  = 1'b0;
        if (m_date[31] && !bcd_ok(d, 1, 31)) b = 1'b1;
        if (m_date[23] && !bcd_ok(mo, 1, 12)) b = 1'b1;
        return b;
    endfunction

    function automatic bit m_fire();
        bit any;
        bit ok = 1'b1;
        any = m_time[7] || m_time[15] || m_time[23] || m_date[23] || m_date[31];
        if (m_time[7]  && int'(m_time % 128) != int'(cur_sec)) ok = 1'b0;
        if (m_time[15] && int'((m_time / 256) % 128) != int'(cur_min)) ok = 1'b0;
        if (m_time[23]) begin
            if (int'((m_time / 65536) % 64) != int'(cur_hour)) ok = 1'b0;
            if (mode_12h && (m_time[22] != cur_pm)) ok = 1'b0;
        end
        if (m_date[23] && int'((m_date / 65536) % 32) != int'(cur_month)) ok = 1'b0;
        if (m_date[31] && int'((m_date / 16777216) % 64) != int'(cur_date)) ok = 1'b0;
        return sec_tick && any && ok && !m_time_bad() && !m_date_bad();
    endfunction

    // reference model update at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_time = 0;
            m_date = 0;
            m_flag = 1'b0;
        end else begin
            if (m_fire())       m_flag = 1'b1;
            else if (alarm_clr) m_flag = 1'b0;
            if (reg_wr) begin
                if (reg_sel) m_date = reg_wdata & 32'hBF9F_0000;
                else         m_time = reg_wdata & 32'h00FF_FFFF;
            end
        end
    end

    // compare every output against the model between edges
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check(alarm_flag == m_flag, "R4 flag vs model", int'(alarm_flag), int'(m_flag));
            check(time_alarm_bad == m_time_bad(), "R9 time non-valid vs model",
                  int'(time_alarm_bad), int'(m_time_bad()));
            check(date_alarm_bad == m_date_bad(), "R9 date non-valid vs model",
                  int'(date_alarm_bad), int'(m_date_bad()));
            check(time_alarm_rd == m_time, "R1 time word vs model", int'(time_alarm_rd), int'(m_time));
            check(date_alarm_rd == m_date, "R1 date word vs model", int'(date_alarm_rd), int'(m_date));
        end
    end

    task automatic write_word(input bit sel, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic set_now(input logic [6:0] s, input logic [6:0] mi, input logic [5:0] h,
                           input logic pm, input logic [5:0] d, input logic [4:0] mo);
        cur_sec = s; cur_min = mi; cur_hour = h; cur_pm = pm; cur_date = d; cur_month = mo;
    endtask

    task automatic tick_once();
        sec_tick = 1'b1;
        @(posedge clk); #1;
        sec_tick = 1'b0;
    endtask

    task automatic clear_flag();
        alarm_clr = 1'b1;
        @(posedge clk); #1;
        alarm_clr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cmp_on = 1'b1;

        // R2 reset state
        check(alarm_flag == 1'b0, "R2 flag after reset", int'(alarm_flag), 0);
        check(time_alarm_rd == 32'h0, "R2 time word after reset", int'(time_alarm_rd), 0);
        check(date_alarm_rd == 32'h0, "R2 date word after reset", int'(date_alarm_rd), 0);
        check(!time_alarm_bad && !date_alarm_bad, "R2 non-valid after reset",
              int'({time_alarm_bad, date_alarm_bad}), 0);

        // R6 nothing enabled, all-zero current values equal the stored zeros
        set_now(7'h00, 7'h00, 6'h00, 1'b0, 6'h00, 5'h00);
        tick_once();
        check(alarm_flag == 1'b0, "R6 no enable no fire", int'(alarm_flag), 0);

        // R3 second-only alarm
        write_word(1'b0, 32'h0000_00B0);
        set_now(7'h29, 7'h11, 6'h08, 1'b0, 6'h05, 5'h03);
        tick_once();
        check(alarm_flag == 1'b0, "R3 mismatch second", int'(alarm_flag), 0);
        cur_sec = 7'h30;
        tick_once();
        check(alarm_flag == 1'b1, "R3 match second", int'(alarm_flag), 1);
        repeat (3) @(posedge clk);
        #1 check(alarm_flag == 1'b1, "R4 flag held", int'(alarm_flag), 1);
        clear_flag();
        check(alarm_flag == 1'b0, "R5 clear", int'(alarm_flag), 0);
        // R7 match held without a tick
        repeat (3) @(posedge clk);
        #1 check(alarm_flag == 1'b0, "R7 no tick no fire", int'(alarm_flag), 0);

        // R8 24-hour: AM/PM ignored
        mode_12h = 1'b0;
        write_word(1'b0, 32'h00D5_0000);
        set_now(7'h00, 7'h00, 6'h15, 1'b0, 6'h01, 5'h01);
        tick_once();
        check(alarm_flag == 1'b1, "R8 24h hour match pm ignored", int'(alarm_flag), 1);
        clear_flag();

        // R8 12-hour: AM/PM compared
        mode_12h = 1'b1;
        write_word(1'b0, 32'h00C7_0000);
        set_now(7'h00, 7'h00, 6'h07, 1'b0, 6'h01, 5'h01);
        tick_once();
        check(alarm_flag == 1'b0, "R8 12h wrong half", int'(alarm_flag), 0);
        cur_pm = 1'b1;
        tick_once();
        check(alarm_flag == 1'b1, "R8 12h right half", int'(alarm_flag), 1);
        clear_flag();
        mode_12h = 1'b0;

        // R3 date and month alarm
        write_word(1'b0, 32'h0);
        write_word(1'b1, 32'hA592_0000);
        set_now(7'h00, 7'h00, 6'h00, 1'b0, 6'h25, 5'h11);
        tick_once();
        check(alarm_flag == 1'b0, "R3 month mismatch", int'(alarm_flag), 0);
        cur_month = 5'h12;
        tick_once();
        check(alarm_flag == 1'b1, "R3 date and month match", int'(alarm_flag), 1);
        clear_flag();
        write_word(1'b1, 32'h0);

        // R9 / R10 illegal second blocks firing
        write_word(1'b0, 32'h0000_00DA);
        #1 check(time_alarm_bad == 1'b1, "R9 second low digit", int'(time_alarm_bad), 1);
        cur_sec = 7'h5A;
        tick_once();
        check(alarm_flag == 1'b0, "R10 bad word blocks", int'(alarm_flag), 0);
        write_word(1'b0, 32'h0000_005A);
        #1 check(time_alarm_bad == 1'b0, "R9 disabled field unchecked", int'(time_alarm_bad), 0);
        write_word(1'b0, 32'h0080_0000);
        mode_12h = 1'b1;
        #1 check(time_alarm_bad == 1'b1, "R9 hour 00 in 12h", int'(time_alarm_bad), 1);
        mode_12h = 1'b0;
        #1 check(time_alarm_bad == 1'b0, "R9 hour 00 in 24h", int'(time_alarm_bad), 0);
        write_word(1'b0, 32'h00A4_0000);
        #1 check(time_alarm_bad == 1'b1, "R9 hour 24 in 24h", int'(time_alarm_bad), 1);
        write_word(1'b1, 32'h0093_0000);
        #1 check(date_alarm_bad == 1'b1, "R9 month 13", int'(date_alarm_bad), 1);
        write_word(1'b1, 32'h8000_0000);
        #1 check(date_alarm_bad == 1'b1, "R9 date 00", int'(date_alarm_bad), 1);

        // R1 masking and word independence
        write_word(1'b0, 32'hFFFF_FFFF);
        check(time_alarm_rd == 32'h00FF_FFFF, "R1 time mask", int'(time_alarm_rd), 32'h00FF_FFFF);
        write_word(1'b1, 32'hFFFF_FFFF);
        check(date_alarm_rd == 32'hBF9F_0000, "R1 date mask", int'(date_alarm_rd), 32'hBF9F_0000);
        check(time_alarm_rd == 32'h00FF_FFFF, "R1 time unchanged by date write",
              int'(time_alarm_rd), 32'h00FF_FFFF);

        // R5 clear and fire together: set wins
        write_word(1'b1, 32'h0);
        write_word(1'b0, 32'h0000_00B0);
        cur_sec = 7'h30;
        alarm_clr = 1'b1;
        tick_once();
        alarm_clr = 1'b0;
        check(alarm_flag == 1'b1, "R5 set beats clear", int'(alarm_flag), 1);
        clear_flag();

        // mixed stimulus checked by the per-cycle model
        for (int k = 0; k < 600; k++) begin
            if (($urandom % 8) == 0) begin
                reg_wr = 1'b1;
                reg_sel = 1'($urandom % 2);
                reg_wdata = {$urandom % 2 == 0, 1'b0,
                             ($urandom % 2) ? 6'h15 : 6'h31,
                             1'($urandom % 2), 2'b00,
                             ($urandom % 2) ? 5'h06 : 5'h12,
                             1'($urandom % 2), 1'($urandom % 2),
                             ($urandom % 3 == 0) ? 6'h00 : 6'h07,
                             1'($urandom % 2),
                             ($urandom % 2) ? 7'h45 : 7'h59,
                             1'($urandom % 2),
                             ($urandom % 2) ? 7'h30 : 7'h6A};
            end else begin
                reg_wr = 1'b0;
            end
            sec_tick  = 1'($urandom % 2);
            alarm_clr = ($urandom % 6) == 0;
            if (($urandom % 20) == 0) mode_12h = ~mode_12h;
            set_now(($urandom % 2) ? 7'h30 : 7'h6A,
                    ($urandom % 2) ? 7'h45 : 7'h59,
                    ($urandom % 3 == 0) ? 6'h00 : 6'h07,
                    1'($urandom % 2),
                    ($urandom % 2) ? 6'h15 : 6'h31,
                    ($urandom % 2) ? 5'h06 : 5'h12);
            @(posedge clk); #1;
        end
        reg_wr = 1'b0;
        sec_tick = 1'b0;
        alarm_clr = 1'b0;
        @(negedge clk);
        @(posedge clk); #1;
        finish_run();
    end

endmodule